// File: doc/BRIEF.md
# PCIe Function Power-State Controller

This block holds the power-management state of one PCIe endpoint function. Software moves the function between the full-power state D0 and the low-power state D3hot by writing a two-bit power-state field; the two unsupported low-power codes are dropped. From the device state and a handful of application inputs the block derives the link state and reports both on encoded status outputs.

The application can wake the function out of D3hot with a one-cycle pulse, which returns it to D0 and raises a PME message request. When a turn-off message arrives while the function is in D3hot, the block waits for the application's readiness level before it requests the L2/L3-entry reply. Once that reply has been handed off, the link sits in L2; losing auxiliary power drops it to L3. A host-initiated exit can only bring the link back from L2. Nothing but reset leaves L3. A pending-transfer input keeps the link out of L1 and pulls it out of L1 if it is already there. Messages leave through a valid/ack handshake to a transmitter.

Device states: `DS_D0`, `DS_D3HOT`. Device transitions: D0 to D3hot on a write of code 3. D3hot to D0 on an accepted wake pulse, on a write of code 0, or on an accepted host exit. Link states: `LK_L0`, `LK_L1`, `LK_L23_HOLD` (turn-off seen, waiting for readiness), `LK_L23_SEND` (entry reply requested, waiting for ack), `LK_L2`, `LK_L3`. Link transitions: L0 to L1 when the function is in D3hot, no transfer is pending and no message is outstanding. L1 to L0 on a pending transfer, on D0, or on an outstanding message. L0 or L1 to HOLD on a turn-off in D3hot. HOLD to SEND on readiness. SEND to L2 on ack. L2 to L0 on host exit. L2 to L3 on aux loss. L3 stays in L3.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the device-state output is 4'b0001 (D0), the link-state output is 8'h01 (L0) and `msg_valid` is low.
- R2: A write of power-state code 3 (D3hot) in D0 sets the device-state output to 4'b1000 after the write edge. A write of code 0 in D3hot returns it to 4'b0001. Writes of codes 1 and 2 are ignored. The output is never any value other than 4'b0001 or 4'b1000.
- R3: The link-state output is one-hot: bit 0 = L0 (also shown during both L2/L3-entry states), bit 2 = L1, bit 3 = L2, bit 4 = L3. The other bits stay zero.
- R4: The link enters L1 (bit 2) from L0 one clock after the device state becomes D3hot, provided no transfer is pending and no message is outstanding. It never enters L1 while a message is outstanding.
- R5: While `xfer_pending` is high, L1 is not entered. If it is raised in L1 without a turn-off, the link shows L0 after the next edge.
- R6: A wake pulse in D3hot with no PME outstanding returns the device state to D0 after that edge and raises `msg_valid` with `msg_type` 2'd1 (PME). The link leaves L1 one edge later.
- R7: A wake pulse while a PME request is still unacknowledged is dropped: the device state does not change and no second PME is queued, so one ack clears `msg_valid`.
- R8: A turn-off in D3hot (from L0 or L1) moves the link to the hold state. The entry reply (`msg_type` 2'd2) is requested only on an edge where `l23_ready` is high. A turn-off in D0 is ignored.
- R9: The ack of the entry reply moves the link to L2 (8'h08) on that edge.
- R10: While the link is in the L2/L3-entry states, L2 or L3, power-state writes and wake pulses are ignored. `aux_lost` moves L2 to L3 (8'h10). `host_l2_exit` in L2 returns the link to L0 and the function to D0. L3 is left only by reset.
- R11: While `msg_valid` is high and not acknowledged, it stays high and `msg_type` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Power-state field write strobe |
| cfg_wr_pstate | input | 2 | Requested state: 0 D0, 1 D1, 2 D2, 3 D3hot |
| wake_pulse | input | 1 | One-cycle application wake request |
| turnoff_rx | input | 1 | One-cycle indication that a turn-off message was received |
| l23_ready | input | 1 | Application ready for L2/L3 entry (level) |
| xfer_pending | input | 1 | Transfer pending; blocks or ends L1 |
| host_l2_exit | input | 1 | Host-initiated exit from L2 |
| aux_lost | input | 1 | Auxiliary power removed (L2 to L3) |
| msg_ack | input | 1 | Transmitter accepts the offered message |
| msg_valid | output | 1 | Message request offered |
| msg_type | output | 2 | 1 = PME, 2 = L2/L3 entry reply, 0 = none |
| dstate_o | output | DST_W | One-hot device state (4'b0001 D0, 4'b1000 D3hot) |
| lstate_o | output | LST_W | One-hot link state |

## Verification
The assertions assume `wake_pulse`, `turnoff_rx`, `host_l2_exit` and `aux_lost` are single-cycle pulses. They also assume `msg_ack` is only raised while `msg_valid` is high. The directed stimulus drives each pulse for exactly one clock and raises the ack only after it has seen a pending message. Inputs change half a cycle away from the active edge, so each registered response is sampled one edge after its cause.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        PS_D0    = 2'd0,
        PS_D1    = 2'd1,
        PS_D2    = 2'd2,
        PS_D3HOT = 2'd3
    } pstate_e;

    typedef enum logic [2:0] {
        LK_L0,
        LK_L1,
        LK_L23_HOLD,
        LK_L23_SEND,
        LK_L2,
        LK_L3
    } link_e;

    typedef enum logic [1:0] {
        MSG_NONE      = 2'd0,
        MSG_PME       = 2'd1,
        MSG_ENTER_L23 = 2'd2
    } msg_e;

endpackage

// File: rtl/pwr_dstate_trk.sv
module pwr_dstate_trk
    import pwr_pkg::*;
#(
    parameter int DST_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_pstate,
    input  logic             wake_pulse,
    input  logic             pme_busy,
    input  logic             frozen,
    input  logic             host_exit,
    output logic             is_d3,
    output logic             wake_acc,
    output logic [DST_W-1:0] dcode
);
    localparam int BIT_D0 = 0;
    localparam int BIT_D3 = DST_W - 1;

    typedef enum logic {DS_D0, DS_D3HOT} dstate_e;

    dstate_e cur, nxt;

    always_comb begin
        nxt      = cur;
        wake_acc = 1'b0;
        if (host_exit) begin
            nxt = DS_D0;
        end else if (!frozen) begin
            unique case (cur)
                DS_D0: begin
                    if (wr_en && pstate_e'(wr_pstate) == PS_D3HOT) nxt = DS_D3HOT;
                end
                DS_D3HOT: begin
                    if (wake_pulse && !pme_busy) begin
                        nxt      = DS_D0;
                        wake_acc = 1'b1;
                    end else if (wr_en && pstate_e'(wr_pstate) == PS_D0) begin
                        nxt = DS_D0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= DS_D0;
        else        cur <= nxt;
    end

    always_comb begin
        dcode = '0;
        is_d3 = 1'b0;
        unique case (cur)
            DS_D0:    dcode[BIT_D0] = 1'b1;
            DS_D3HOT: begin
                dcode[BIT_D3] = 1'b1;
                is_d3         = 1'b1;
            end
        endcase
    end

    // R2: only the two legal codes appear
    a_r2_dcode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(dcode) && (dcode[BIT_D0] || dcode[BIT_D3])));

    // R2: unsupported codes leave the state alone
    a_r2_ignore_d1_d2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_pstate == 2'd1 || wr_pstate == 2'd2) && !wake_pulse && !host_exit)
        |=> $stable(dcode));

    // R10: link-off states freeze the device state
    a_r10_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !host_exit) |=> $stable(dcode));

    // R7: no wake accepted while a PME is outstanding
    a_r7_no_double_pme: assert property (@(posedge clk) disable iff (!rst_n)
        pme_busy |-> !wake_acc);

endmodule

// File: rtl/pwr_link_fsm.sv
module pwr_link_fsm
    import pwr_pkg::*;
#(
    parameter int LST_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_d3,
    input  logic             turnoff_rx,
    input  logic             l23_ready,
    input  logic             xfer_pending,
    input  logic             msg_busy,
    input  logic             l23_done,
    input  logic             host_exit_rq,
    input  logic             aux_lost,
    output logic             l23_req,
    output logic             frozen,
    output logic             host_exit,
    output logic [LST_W-1:0] lcode
);
    localparam int BIT_L0 = 0;
    localparam int BIT_L1 = 2;
    localparam int BIT_L2 = 3;
    localparam int BIT_L3 = 4;

    link_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            LK_L0: begin
                if (turnoff_rx && is_d3)                          nxt = LK_L23_HOLD;
                else if (is_d3 && !xfer_pending && !msg_busy)     nxt = LK_L1;
            end
            LK_L1: begin
                if (turnoff_rx && is_d3)                          nxt = LK_L23_HOLD;
                else if (xfer_pending || !is_d3 || msg_busy)      nxt = LK_L0;
            end
            LK_L23_HOLD: if (l23_ready)    nxt = LK_L23_SEND;
            LK_L23_SEND: if (l23_done)     nxt = LK_L2;
            LK_L2: begin
                if (host_exit_rq)          nxt = LK_L0;
                else if (aux_lost)         nxt = LK_L3;
            end
            LK_L3:                         nxt = LK_L3;
            default:                       nxt = LK_L0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LK_L0;
        else        state <= nxt;
    end

    always_comb begin
        lcode     = '0;
        l23_req   = 1'b0;
        frozen    = 1'b1;
        host_exit = 1'b0;
        unique case (state)
            LK_L0: begin
                lcode[BIT_L0] = 1'b1;
                frozen        = 1'b0;
            end
            LK_L1: begin
                lcode[BIT_L1] = 1'b1;
                frozen        = 1'b0;
            end
            LK_L23_HOLD: begin
                lcode[BIT_L0] = 1'b1;
                l23_req       = l23_ready;
            end
            LK_L23_SEND: lcode[BIT_L0] = 1'b1;
            LK_L2: begin
                lcode[BIT_L2] = 1'b1;
                host_exit     = host_exit_rq;
            end
            LK_L3:   lcode[BIT_L3] = 1'b1;
            default: lcode[BIT_L0] = 1'b1;
        endcase
    end

    // R3: exactly one link-state bit
    a_r3_lcode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(lcode));

    // R5: no L1 entry while a transfer is pending
    a_r5_no_l1_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_L0 && xfer_pending) |=> state != LK_L1);

    // R5: pending transfer pulls the link out of L1
    a_r5_l1_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_L1 && xfer_pending && !turnoff_rx) |=> state == LK_L0);

    // R4: no L1 entry with a message outstanding
    a_r4_no_l1_msg: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_L0 && msg_busy) |=> state != LK_L1);

    // R8: hold until the application is ready
    a_r8_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_L23_HOLD && !l23_ready) |=> state == LK_L23_HOLD);

    // R9: accepted entry reply lands in L2
    a_r9_enter_l2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_L23_SEND && l23_done) |=> state == LK_L2);

    // R10: L3 is only left by reset
    a_r10_l3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_L3) |=> state == LK_L3);

endmodule

// File: rtl/pwr_msg_req.sv
module pwr_msg_req
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_acc,
    input  logic       l23_req,
    input  logic       msg_ack,
    output logic       msg_valid,
    output logic [1:0] msg_type,
    output logic       pme_busy,
    output logic       l23_done
);
    logic pme_pend, l23_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pme_pend <= 1'b0;
            l23_pend <= 1'b0;
        end else begin
            if (wake_acc)                  pme_pend <= 1'b1;
            else if (msg_ack && pme_pend)  pme_pend <= 1'b0;
            if (l23_req)                   l23_pend <= 1'b1;
            else if (l23_done)             l23_pend <= 1'b0;
        end
    end

    always_comb begin
        msg_valid = pme_pend | l23_pend;
        pme_busy  = pme_pend;
        l23_done  = msg_ack && l23_pend && !pme_pend;
        if (pme_pend)      msg_type = MSG_PME;
        else if (l23_pend) msg_type = MSG_ENTER_L23;
        else               msg_type = MSG_NONE;
    end

    // R11: offered message is held until acknowledged
    a_r11_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_type)));

    // R6: an accepted wake always offers a PME next
    a_r6_pme_raised: assert property (@(posedge clk) disable iff (!rst_n)
        wake_acc |=> (msg_valid && msg_type == MSG_PME));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int DST_W = 4,
    parameter int LST_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_wr_pstate,
    input  logic             wake_pulse,
    input  logic             turnoff_rx,
    input  logic             l23_ready,
    input  logic             xfer_pending,
    input  logic             host_l2_exit,
    input  logic             aux_lost,
    input  logic             msg_ack,
    output logic             msg_valid,
    output logic [1:0]       msg_type,
    output logic [DST_W-1:0] dstate_o,
    output logic [LST_W-1:0] lstate_o
);
    logic is_d3, wake_acc, pme_busy, l23_done, l23_req, frozen, host_exit;

    pwr_dstate_trk #(.DST_W(DST_W)) u_dst (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_pstate(cfg_wr_pstate),
        .wake_pulse(wake_pulse), .pme_busy(pme_busy),
        .frozen(frozen), .host_exit(host_exit),
        .is_d3(is_d3), .wake_acc(wake_acc), .dcode(dstate_o)
    );

    pwr_link_fsm #(.LST_W(LST_W)) u_link (
        .clk(clk), .rst_n(rst_n),
        .is_d3(is_d3), .turnoff_rx(turnoff_rx), .l23_ready(l23_ready),
        .xfer_pending(xfer_pending), .msg_busy(msg_valid),
        .l23_done(l23_done), .host_exit_rq(host_l2_exit), .aux_lost(aux_lost),
        .l23_req(l23_req), .frozen(frozen), .host_exit(host_exit),
        .lcode(lstate_o)
    );

    pwr_msg_req u_msg (
        .clk(clk), .rst_n(rst_n),
        .wake_acc(wake_acc), .l23_req(l23_req), .msg_ack(msg_ack),
        .msg_valid(msg_valid), .msg_type(msg_type),
        .pme_busy(pme_busy), .l23_done(l23_done)
    );

    // R1: state right after reset release
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (dstate_o == 4'b0001 && lstate_o == 8'h01 && !msg_valid));

endmodule

// File: tb/sim_pwr_state_ctrl.sv
module sim_pwr_state_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_pstate = 2'd0;
    logic wake_pulse = 1'b0, turnoff_rx = 1'b0, l23_ready = 1'b0;
    logic xfer_pending = 1'b0, host_l2_exit = 1'b0, aux_lost = 1'b0, msg_ack = 1'b0;
    logic msg_valid;
    logic [1:0] msg_type;
    logic [3:0] dstate_o;
    logic [7:0] lstate_o;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [3:0] D0 = 4'b0001, D3 = 4'b1000;
    localparam logic [7:0] L0 = 8'h01, L1 = 8'h04, L2 = 8'h08, L3 = 8'h10;

    always #4 clk = ~clk;

    pwr_state_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_pstate(cfg_wr_pstate),
        .wake_pulse(wake_pulse), .turnoff_rx(turnoff_rx), .l23_ready(l23_ready),
        .xfer_pending(xfer_pending), .host_l2_exit(host_l2_exit), .aux_lost(aux_lost),
        .msg_ack(msg_ack), .msg_valid(msg_valid), .msg_type(msg_type),
        .dstate_o(dstate_o), .lstate_o(lstate_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic write_ps(input logic [1:0] code);
        cfg_wr_en = 1'b1; cfg_wr_pstate = code;
        tick(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_pulse = 1'b1; tick(1); wake_pulse = 1'b0;
    endtask

    task automatic pulse_ack();
        msg_ack = 1'b1; tick(1); msg_ack = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 dstate", dstate_o, D0);
        check("R1 lstate", lstate_o, L0);
        check("R1 msg_valid", msg_valid, 0);
    endtask

    task automatic t_dstate_writes();
        do_reset();
        write_ps(2'd1);
        check("R2 D1 ignored", dstate_o, D0);
        write_ps(2'd2);
        check("R2 D2 ignored", dstate_o, D0);
        xfer_pending = 1'b1;
        write_ps(2'd3);
        check("R2 D3hot code", dstate_o, D3);
        write_ps(2'd1);
        check("R2 D1 ignored in D3hot", dstate_o, D3);
        write_ps(2'd0);
        check("R2 back to D0", dstate_o, D0);
        xfer_pending = 1'b0;
        tick(1);
        check("R3 L0 bit", lstate_o, L0);
    endtask

    task automatic t_l1_entry();
        do_reset();
        write_ps(2'd3);
        check("R4 still L0 on write edge", lstate_o, L0);
        tick(1);
        check("R4 L1 entered", lstate_o, L1);
        check("R3 L1 bit", lstate_o, 8'h04);
    endtask

    task automatic t_xfer_pending();
        do_reset();
        xfer_pending = 1'b1;
        write_ps(2'd3);
        tick(3);
        check("R5 no L1 while pending", lstate_o, L0);
        xfer_pending = 1'b0;
        tick(1);
        check("R5 L1 after release", lstate_o, L1);
        xfer_pending = 1'b1;
        tick(1);
        check("R5 L1 exit on pending", lstate_o, L0);
        xfer_pending = 1'b0;
        tick(1);
    endtask

    task automatic t_wake();
        do_reset();
        write_ps(2'd3);
        tick(1);
        pulse_wake();
        check("R6 back to D0", dstate_o, D0);
        check("R6 msg_valid", msg_valid, 1);
        check("R6 PME type", msg_type, 2'd1);
        tick(1);
        check("R6 link leaves L1", lstate_o, L0);
        tick(3);
        check("R11 valid held", msg_valid, 1);
        check("R11 type held", msg_type, 2'd1);
        pulse_ack();
        check("R6 cleared by ack", msg_valid, 0);
    endtask

    task automatic t_wake_drop();
        do_reset();
        write_ps(2'd3);
        tick(1);
        pulse_wake();
        write_ps(2'd3);
        check("R4 no L1 with msg outstanding", lstate_o, L0);
        pulse_wake();
        check("R7 dstate unchanged", dstate_o, D3);
        check("R7 still PME", msg_type, 2'd1);
        pulse_ack();
        check("R7 single ack clears", msg_valid, 0);
        tick(1);
        check("R4 L1 after ack", lstate_o, L1);
    endtask

    task automatic reach_l2();
        do_reset();
        write_ps(2'd3);
        tick(1);
        turnoff_rx = 1'b1; l23_ready = 1'b0;
        tick(1);
        turnoff_rx = 1'b0;
        tick(3);
        check("R8 no reply before ready", msg_valid, 0);
        check("R8 hold shows L0", lstate_o, L0);
        write_ps(2'd0);
        check("R10 write ignored in hold", dstate_o, D3);
        l23_ready = 1'b1;
        tick(1);
        l23_ready = 1'b0;
        check("R8 reply requested", msg_valid, 1);
        check("R8 reply type", msg_type, 2'd2);
        pulse_ack();
        check("R9 L2 after ack", lstate_o, L2);
        check("R9 msg cleared", msg_valid, 0);
    endtask

    task automatic t_turnoff_d0();
        do_reset();
        turnoff_rx = 1'b1; tick(1); turnoff_rx = 1'b0;
        l23_ready = 1'b1;
        tick(2);
        l23_ready = 1'b0;
        check("R8 turnoff in D0 no msg", msg_valid, 0);
        write_ps(2'd3);
        check("R8 turnoff in D0 not frozen", dstate_o, D3);
    endtask

    task automatic t_l2_l3();
        reach_l2();
        pulse_wake();
        check("R10 wake ignored in L2", dstate_o, D3);
        check("R10 no PME in L2", msg_valid, 0);
        host_l2_exit = 1'b1; tick(1); host_l2_exit = 1'b0;
        check("R10 host exit to L0", lstate_o, L0);
        check("R10 host exit to D0", dstate_o, D0);
        reach_l2();
        aux_lost = 1'b1; tick(1); aux_lost = 1'b0;
        check("R10 L3 entered", lstate_o, L3);
        host_l2_exit = 1'b1; tick(1); host_l2_exit = 1'b0;
        tick(2);
        check("R10 L3 sticky", lstate_o, L3);
        do_reset();
        check("R10 reset leaves L3", lstate_o, L0);
    endtask

    initial begin
        t_reset();
        t_dstate_writes();
        t_l1_entry();
        t_xfer_pending();
        t_wake();
        t_wake_drop();
        t_turnoff_d0();
        t_l2_l3();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule